// File: doc/BRIEF.md
# Busy-History Fill Criticality Predictor

This block decides where a returning cache fill should be written: into the main first-level data cache or into a small side buffer meant for latency-tolerant data. It does not look at the load itself. It judges the load by how busy the processor has been lately. Every clock cycle it compares a selectable activity measure against a busy threshold and records one bit into a history shift register. The measure is either the count of functional units in use or the count of instructions newly ready to issue.

When the fill logic raises a request, the block counts the recorded busy cycles inside the configured window and answers in the same cycle. A processor that stayed busy while the miss was outstanding kept doing useful work, so the data is judged tolerant and goes to the side buffer. Otherwise the data is judged critical and goes to the main cache. The window length, the busy threshold and the count threshold are run-time configuration inputs. With its default parameters the block uses a window of up to 16 cycles.

Top module: `fill_crit_predictor`

## Requirements
- R1: A cycle is recorded as busy (1) only when the selected activity count is strictly greater than `cfg_busy_thr`; a count equal to or below the threshold records 0.
- R2: `metric_sel` = 0 selects `fu_busy_cnt` and `metric_sel` = 1 selects `ready_cnt`; the unselected count has no effect on the recorded history.
- R3: Exactly one bit is recorded on every rising clock edge outside reset, and the newest bit sits at history position 0. The window therefore spans the most recent `cfg_hist_len` cycles.
- R4: While `fill_req` is high, `place_ncb` = 1 when the number of busy cycles in the window is greater than `cfg_crit_thr`; otherwise `place_main` = 1. The answer is combinational in the request cycle.
- R5: Only the number of busy cycles in the window matters; different orderings with the same count give the same placement.
- R6: History positions at or above the window length are excluded from the count. A `cfg_hist_len` above 16 acts as 16, and a length of 0 always gives main-cache placement.
- R7: Reset clears the history, so a fill requested right after reset goes to the main cache for any `cfg_crit_thr`.
- R8: The bit recorded in the cycle of a request does not influence that request's placement; it counts from the next cycle on.
- R9: `place_main` and `place_ncb` are never high together, and both are low while `fill_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| metric_sel | input | 1 | 0: functional-unit count, 1: ready-instruction count |
| fu_busy_cnt | input | 5 | Functional units in use this cycle |
| ready_cnt | input | 5 | Instructions newly ready to issue this cycle |
| cfg_busy_thr | input | 5 | Busy threshold on the selected count |
| cfg_hist_len | input | 5 | Window length in cycles (0 to 16, larger clamps) |
| cfg_crit_thr | input | 5 | Busy-cycle count above which a fill is tolerant |
| fill_req | input | 1 | A fill placement decision is requested |
| place_main | output | 1 | Place the fill in the main cache |
| place_ncb | output | 1 | Place the fill in the side buffer |

## Verification
The bench builds the block with its defaults: a 16-deep history and 5-bit counts. This lets one test cover a length of 31 clamped to 16, a fully busy 16-cycle window, a zero-length window, and the length-6, threshold-6, count-3 setting used in the pattern table. A table of six-cycle busy patterns walks both metric selections while the unselected count is driven opposite. The patterns compare equal-count orderings and window lengths shorter than the pattern. Directed tests cover the reset state, the equal-to-threshold boundary, a window sliding off its oldest bit, and a request made in the same cycle as a busy sample.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

    typedef enum logic {
        METRIC_FU_UTIL  = 1'b0,
        METRIC_READY    = 1'b1
    } metric_e;

    function automatic int unsigned len_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/fcp_busy_detect.sv
module fcp_busy_detect
    import fcp_pkg::*;
#(
    parameter int MET_W = 5
) (
    input  metric_e            sel,
    input  logic [MET_W-1:0]   fu_cnt,
    input  logic [MET_W-1:0]   rdy_cnt,
    input  logic [MET_W-1:0]   busy_thr,
    output logic               busy_bit
);

    logic [MET_W-1:0] chosen;

    always_comb begin
        unique case (sel)
            METRIC_FU_UTIL: chosen = fu_cnt;
            METRIC_READY:   chosen = rdy_cnt;
            default:        chosen = fu_cnt;
        endcase
        busy_bit = (chosen > busy_thr);
    end

endmodule

// File: rtl/fcp_history.sv
module fcp_history #(
    parameter int HIST_MAX = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    output logic [HIST_MAX-1:0] hist
);

    logic [HIST_MAX-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[HIST_MAX-2:0], bit_in};
        end
    end

    assign hist = hist_q;

    // R3: newest sample lands at position 0
    a_r3_newest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hist_q[0] == $past(bit_in));

    // R3: older samples move up one place per cycle
    a_r3_slide_up: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hist_q[HIST_MAX-1:1] == $past(hist_q[HIST_MAX-2:0]));

endmodule

// File: rtl/fcp_popcount.sv
module fcp_popcount #(
    parameter int HIST_MAX = 16,
    parameter int LEN_W    = 5
) (
    input  logic [HIST_MAX-1:0] hist,
    input  logic [LEN_W-1:0]    len_raw,
    output logic [LEN_W-1:0]    len_eff,
    output logic [LEN_W-1:0]    ones
);

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(HIST_MAX);

    logic [HIST_MAX-1:0] win_mask;

    always_comb begin
        len_eff = (len_raw > LEN_CAP) ? LEN_CAP : len_raw;
    end

    for (genvar g = 0; g < HIST_MAX; g++) begin : g_mask
        assign win_mask[g] = (LEN_W'(g) < len_eff);
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < HIST_MAX; i++) begin
            if (win_mask[i] && hist[i]) begin
                ones = ones + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/fill_crit_predictor.sv
module fill_crit_predictor
    import fcp_pkg::*;
#(
    parameter int HIST_MAX = 16,
    parameter int MET_W    = 5,
    localparam int LEN_W   = len_bits(HIST_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              metric_sel,
    input  logic [MET_W-1:0]  fu_busy_cnt,
    input  logic [MET_W-1:0]  ready_cnt,
    input  logic [MET_W-1:0]  cfg_busy_thr,
    input  logic [LEN_W-1:0]  cfg_hist_len,
    input  logic [LEN_W-1:0]  cfg_crit_thr,
    input  logic              fill_req,
    output logic              place_main,
    output logic              place_ncb
);

    logic                busy_now;
    logic [HIST_MAX-1:0] hist;
    logic [LEN_W-1:0]    len_eff;
    logic [LEN_W-1:0]    ones_cnt;
    logic                tolerant;
    metric_e             sel_e;

    assign sel_e = metric_e'(metric_sel);

    fcp_busy_detect #(.MET_W(MET_W)) u_busy (
        .sel      (sel_e),
        .fu_cnt   (fu_busy_cnt),
        .rdy_cnt  (ready_cnt),
        .busy_thr (cfg_busy_thr),
        .busy_bit (busy_now)
    );

    fcp_history #(.HIST_MAX(HIST_MAX)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (busy_now),
        .hist   (hist)
    );

    fcp_popcount #(.HIST_MAX(HIST_MAX), .LEN_W(LEN_W)) u_pop (
        .hist    (hist),
        .len_raw (cfg_hist_len),
        .len_eff (len_eff),
        .ones    (ones_cnt)
    );

    always_comb begin
        tolerant   = (ones_cnt > cfg_crit_thr);
        place_ncb  = fill_req &&  tolerant;
        place_main = fill_req && !tolerant;
    end

    // R9: the two placements exclude each other
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(place_main && place_ncb));

    // R9: no placement without a request
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_req |-> (!place_main && !place_ncb));

    // R4: every request gets exactly one placement
    a_r4_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (place_main != place_ncb));

    // R6: the count never exceeds the clamped window
    a_r6_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt <= len_eff);

    // R6: an empty window counts nothing
    a_r6_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (len_eff == '0) |-> (ones_cnt == '0));

    // R7: history is empty on leaving reset
    a_r7_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ones_cnt == '0));

endmodule

// File: tb/fill_crit_predictor_test.sv
`timescale 1ns/1ps
module fill_crit_predictor_test;

    localparam int BUSY_THR = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       metric_sel = 1'b0;
    logic [4:0] fu_busy_cnt = '0;
    logic [4:0] ready_cnt = '0;
    logic [4:0] cfg_busy_thr = 5'(BUSY_THR);
    logic [4:0] cfg_hist_len = 5'd6;
    logic [4:0] cfg_crit_thr = 5'd3;
    logic       fill_req = 1'b0;
    logic       place_main;
    logic       place_ncb;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fill_crit_predictor uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .metric_sel   (metric_sel),
        .fu_busy_cnt  (fu_busy_cnt),
        .ready_cnt    (ready_cnt),
        .cfg_busy_thr (cfg_busy_thr),
        .cfg_hist_len (cfg_hist_len),
        .cfg_crit_thr (cfg_crit_thr),
        .fill_req     (fill_req),
        .place_main   (place_main),
        .place_ncb    (place_ncb)
    );

    // {pattern[17:12] oldest first, len[11:7], crit[6:2], sel[1], expect_ncb[0]}
    localparam logic [17:0] VEC [10] = '{
        {6'b111000, 5'd6, 5'd3, 1'b0, 1'b0},
        {6'b101010, 5'd6, 5'd3, 1'b1, 1'b0},
        {6'b111100, 5'd6, 5'd3, 1'b0, 1'b1},
        {6'b111111, 5'd6, 5'd3, 1'b1, 1'b1},
        {6'b000000, 5'd6, 5'd3, 1'b0, 1'b0},
        {6'b110000, 5'd4, 5'd1, 1'b1, 1'b0},
        {6'b000011, 5'd4, 5'd1, 1'b0, 1'b1},
        {6'b111111, 5'd0, 5'd0, 1'b1, 1'b0},
        {6'b100001, 5'd6, 5'd1, 1'b0, 1'b1},
        {6'b011111, 5'd6, 5'd5, 1'b1, 1'b0}
    };

    task automatic drive_metric(input logic busy, input logic sel, input logic at_thr);
        logic [4:0] hit;
        logic [4:0] miss;
        hit  = 5'(BUSY_THR + 1);
        miss = at_thr ? 5'(BUSY_THR) : 5'd0;
        metric_sel = sel;
        if (sel) begin
            ready_cnt   = busy ? hit : miss;
            fu_busy_cnt = busy ? 5'd0 : 5'd31;
        end else begin
            fu_busy_cnt = busy ? hit : miss;
            ready_cnt   = busy ? 5'd0 : 5'd31;
        end
    endtask

    task automatic push(input logic busy, input logic sel);
        @(negedge clk);
        fill_req = 1'b0;
        drive_metric(busy, sel, 1'b0);
    endtask

    task automatic check_pair(input logic req, input logic exp_ncb, input string tag);
        logic exp_main;
        exp_main = req && !exp_ncb;
        n_chk++;
        if (place_ncb !== (req && exp_ncb) || place_main !== exp_main) begin
            n_fail++;
            $display("FAIL %s: main=%0b ncb=%0b expected main=%0b ncb=%0b",
                     tag, place_main, place_ncb, exp_main, req && exp_ncb);
        end
    endtask

    task automatic request(input logic exp_ncb, input string tag);
        @(negedge clk);
        drive_metric(1'b0, metric_sel, 1'b0);
        fill_req = 1'b1;
        #1;
        check_pair(1'b1, exp_ncb, tag);
        fill_req = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state, no request -> no placement
        #1;
        check_pair(1'b0, 1'b0, "R9 idle during reset");
        rst_n = 1'b1;

        // R7: empty history after reset -> main even with crit threshold 0
        cfg_hist_len = 5'd16;
        cfg_crit_thr = 5'd0;
        request(1'b0, "R7 cleared history is critical");

        // R4 R5 R2 R6: table of patterns
        for (int v = 0; v < 10; v++) begin
            cfg_hist_len = VEC[v][11:7];
            cfg_crit_thr = VEC[v][6:2];
            for (int b = 5; b >= 0; b--) begin
                push(VEC[v][12 + b], VEC[v][1]);
            end
            request(VEC[v][0], $sformatf("R4/R5/R2/R6 vector %0d", v));
        end

        // R9: request low after table -> quiet
        @(negedge clk);
        #1;
        check_pair(1'b0, 1'b0, "R9 no request no placement");

        // R1: metric equal to threshold is not busy
        cfg_hist_len = 5'd1;
        cfg_crit_thr = 5'd0;
        @(negedge clk);
        fill_req = 1'b0;
        drive_metric(1'b0, 1'b0, 1'b1);
        request(1'b0, "R1 equal to threshold not busy");
        push(1'b1, 1'b0);
        request(1'b1, "R1 above threshold busy");

        // R8: busy sample in request cycle counts only afterwards
        push(1'b0, 1'b1);
        @(negedge clk);
        drive_metric(1'b1, 1'b1, 1'b0);
        fill_req = 1'b1;
        #1;
        check_pair(1'b1, 1'b0, "R8 same-cycle sample not yet counted");
        @(negedge clk);
        drive_metric(1'b0, 1'b1, 1'b0);
        #1;
        check_pair(1'b1, 1'b1, "R8 sample counted next cycle");
        fill_req = 1'b0;

        // R3: window slides, oldest bit falls out
        cfg_hist_len = 5'd3;
        cfg_crit_thr = 5'd2;
        push(1'b1, 1'b0);
        push(1'b1, 1'b0);
        push(1'b1, 1'b0);
        request(1'b1, "R3 three busy in window of three");
        push(1'b0, 1'b0);
        request(1'b0, "R3 window slid past busy cycles");

        // R6: length above 16 clamps to 16
        cfg_hist_len = 5'd31;
        cfg_crit_thr = 5'd15;
        for (int k = 0; k < 16; k++) push(1'b1, 1'b1);
        request(1'b1, "R6 clamped window full of busy");
        cfg_crit_thr = 5'd16;
        push(1'b1, 1'b1);
        request(1'b0, "R6 clamped count cannot exceed 16");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule